// File: doc/BRIEF.md
# I2C EEPROM Write Command Front End

This block sits on the slave side of a two-wire serial bus in front of a 128 KiB byte-addressable EEPROM array. It oversamples SCL and SDA on the system clock and detects Start and Stop conditions. It decodes the control byte and then collects a 17-bit word address, followed by any number of data bytes. Each data byte goes to a downstream page-buffer engine as a one-cycle strobe, together with the address it belongs to. A Stop after data asks the engine to run the internal write cycle. If write protect is active at that Stop, the block tells the engine to drop the buffered bytes instead.

While the engine reports a write cycle in progress, the block refuses the control byte that opened that write. This lets a bus master poll for completion. A control byte that carries the other block-select value is still served. Read transfers, clock stretching and pad electrical behaviour belong elsewhere.

Top module: `i2cw_frontend`

## Requirements
- R1: A Start is an SDA fall while SCL is high, and a Stop is an SDA rise while SCL is high. Both are judged on the synchronized line values. Bits are taken MSB first on each SCL rise.
- R2: A control byte is accepted only when all of these hold: bits 7:4 equal 1010, bits 2:1 equal `strap_i`, and bit 0 is 0. An accepted byte is acknowledged by holding `sda_oe_o` high from the SCL fall after the eighth bit to the SCL fall that ends the ninth clock. `sda_oe_o` is 0 out of reset.
- R3: A rejected control byte gets no acknowledge. Until the next Start, no later byte is acknowledged and nothing is strobed.
- R4: After an accepted control byte, the next byte is the address high byte and the one after it is the address low byte, and both are acknowledged. The word address is {control bit 3, high byte, low byte}.
- R5: Every data byte is acknowledged and presented on `wr_data_o` with its address on `wr_addr_o`, during a single-cycle `wr_vld_o` pulse.
- R6: After each data byte, address bits 6:0 increment and wrap inside the 128-byte page. Bits 16:7 do not change.
- R7: A Stop that follows at least one data byte, with `wp_i` low in the Stop cycle, gives exactly one single-cycle `commit_o` pulse.
- R8: If `wp_i` is high when such a Stop is seen, `discard_o` pulses instead of `commit_o`. All bytes of the command are still acknowledged, and the next command is accepted at once.
- R9: While `cycle_busy_i` is high, a control byte whose bit 3 equals bit 3 of the control byte behind the last commit is not acknowledged. The other bit 3 value is acknowledged.
- R10: A Start received in any state restarts control-byte decoding. If data bytes had already been strobed in the interrupted command, `discard_o` pulses.
- R11: A Stop that arrives before any data byte produces neither `commit_o` nor `discard_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 2 | Static device-select straps compared with control bits 2:1 |
| wp_i | input | 1 | Write protect, sampled at Stop |
| cycle_busy_i | input | 1 | High while the engine runs an internal write cycle |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) when high |
| wr_vld_o | output | 1 | One-cycle data byte strobe |
| wr_addr_o | output | 17 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle request to write the buffered page |
| discard_o | output | 1 | One-cycle request to drop the buffered bytes |

## Verification
Directed commands cover several cases: a single-byte write in the upper block, which checks how the address is assembled, and a run that crosses a page end, which separates wrapping from carrying into bit 7. Control bytes that are wrong only in the code, only in the straps or only in direction each show that rejection leaves the rest of the command unanswered. Busy polling is tried with both block-select values to show that only the matching one is refused. Repeated Starts placed before and after data, protected Stops and address-only commands separate commit, discard and silence. Seeded random commands then mix good and bad control bytes, random addresses, lengths from zero to five, protect and busy. Each is compared against acknowledge, strobe and pulse counts predicted by bench functions.

// File: rtl/i2cw_pkg.sv
// Package: shared constants and types for the serial EEPROM write front end.
// Assumes a 17-bit byte address made of one block bit and two address bytes.
package i2cw_pkg;
    localparam logic [3:0] CTRL_CODE = 4'b1010;
    localparam int         BYTE_W    = 8;
    localparam int         ADDR_W    = 2 * BYTE_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until a Start
        ST_CTRL,   // expecting the control byte
        ST_AHI,    // expecting the address high byte
        ST_ALO,    // expecting the address low byte
        ST_DATA    // collecting data bytes
    } fe_state_e;
endpackage

// File: rtl/i2cw_line_sync.sv
// Module: brings SCL/SDA into the clock domain and flags line events.
// Assumes the system clock is several times faster than SCL; lines idle high.
module i2cw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    generate
        if (STAGES > 1) begin : g_chain
            logic [STAGES-1:0] scl_sh;
            logic [STAGES-1:0] sda_sh;
            // Shift raw lines through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
            assign scl_s = scl_sh[STAGES-1];
            assign sda_s = sda_sh[STAGES-1];
        end else begin : g_single
            logic scl_r;
            logic sda_r;
            // Single-flop capture when only one stage is asked for.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_i;
                    sda_r <= sda_i;
                end
            end
            assign scl_s = scl_r;
            assign sda_s = sda_r;
        end
    endgenerate

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode clock edges and the Start/Stop conditions.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cw_byte_rx.sv
// Module: assembles bus bytes MSB first and drives the ninth-clock acknowledge.
// Assumes the owner answers ack_en in the same cycle that byte_done is high.
module i2cw_byte_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            restart,
    input  logic            ack_en,
    output logic            byte_done,
    output logic [BITS-1:0] rx_byte,
    output logic            sda_oe
);
    localparam int CW = $clog2(BITS + 1);

    logic [CW-1:0]   bit_cnt;
    logic [BITS-1:0] shreg;
    logic            in_ack;

    // A byte is complete at the SCL fall that follows its last bit.
    assign byte_done = scl_fall & ~in_ack & (bit_cnt == CW'(BITS)) & ~restart;
    assign rx_byte   = shreg;

    // Count bits, shift data and own the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (restart) begin
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (scl_rise && !in_ack && bit_cnt < CW'(BITS)) begin
            shreg   <= {shreg[BITS-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall) begin
            if (in_ack) begin
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (bit_cnt == CW'(BITS)) begin
                in_ack <= 1'b1;
                sda_oe <= ack_en;
            end
        end
    end

    // R2
    ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2cw_frontend.sv
// Module: top of the write front end. Decodes control, address and data bytes,
// strobes bytes to the page engine and requests commit or discard at Stop.
// Assumes strap_i is static and cycle_busy_i rises soon after commit_o.
module i2cw_frontend #(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_BITS   = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  strap_i,
    input  logic        wp_i,
    input  logic        cycle_busy_i,
    output logic        sda_oe_o,
    output logic        wr_vld_o,
    output logic [16:0] wr_addr_o,
    output logic [7:0]  wr_data_o,
    output logic        commit_o,
    output logic        discard_o
);
    import i2cw_pkg::*;

    localparam int HI_MSB = ADDR_W - 2;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_done, ack_en, ctrl_ok;
    logic [BYTE_W-1:0] rx_byte;
    fe_state_e         state;
    logic [ADDR_W-1:0] addr;
    logic              data_seen;
    logic              pend_blk;

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cw_byte_rx #(.BITS(BYTE_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .restart(start_det | stop_det), .ack_en(ack_en),
        .byte_done(byte_done), .rx_byte(rx_byte), .sda_oe(sda_oe_o)
    );

    // Judge the control byte: code, straps, write direction and busy polling.
    always_comb begin
        ctrl_ok = (rx_byte[7:4] == CTRL_CODE) && (rx_byte[2:1] == strap_i) &&
                  !rx_byte[0] && !(cycle_busy_i && (rx_byte[3] == pend_blk));
    end

    // Decide whether the byte just finished earns an acknowledge.
    always_comb begin
        case (state)
            ST_CTRL:                ack_en = ctrl_ok;
            ST_AHI, ST_ALO, ST_DATA: ack_en = 1'b1;
            default:                ack_en = 1'b0;
        endcase
    end

    // Command sequencing, address tracking and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr      <= '0;
            data_seen <= 1'b0;
            pend_blk  <= 1'b0;
            wr_vld_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            commit_o  <= 1'b0;
            discard_o <= 1'b0;
        end else begin
            wr_vld_o  <= 1'b0;
            commit_o  <= 1'b0;
            discard_o <= 1'b0;
            if (start_det) begin
                if (state == ST_DATA && data_seen) discard_o <= 1'b1;
                state     <= ST_CTRL;
                data_seen <= 1'b0;
            end else if (stop_det) begin
                if (state == ST_DATA && data_seen) begin
                    if (wp_i) begin
                        discard_o <= 1'b1;
                    end else begin
                        commit_o <= 1'b1;
                        pend_blk <= addr[ADDR_W-1];
                    end
                end
                state     <= ST_IDLE;
                data_seen <= 1'b0;
            end else if (byte_done) begin
                case (state)
                    ST_CTRL: begin
                        if (ctrl_ok) begin
                            addr[ADDR_W-1] <= rx_byte[3];
                            state          <= ST_AHI;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        addr[HI_MSB -: BYTE_W] <= rx_byte;
                        state                  <= ST_ALO;
                    end
                    ST_ALO: begin
                        addr[BYTE_W-1:0] <= rx_byte;
                        state            <= ST_DATA;
                    end
                    ST_DATA: begin
                        wr_vld_o  <= 1'b1;
                        wr_addr_o <= addr;
                        wr_data_o <= rx_byte;
                        data_seen <= 1'b1;
                        addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7
    commit_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !$past(wp_i));
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && discard_o));
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_CTRL));
    // R5
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld_o |-> $past(state == ST_DATA));
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_det) |=> !wr_vld_o);
endmodule

// File: tb/test_i2cw_frontend.sv
module test_i2cw_frontend;
    localparam int Q = 4;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic busy = 1'b0;
    logic sda_oe, wr_vld, commit, discard;
    logic [16:0] wr_addr;
    logic [7:0] wr_data;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [16:0] cap_addr [0:255];
    logic [7:0]  cap_data [0:255];
    int cap_n = 0;
    int commit_n = 0;
    int discard_n = 0;
    logic [7:0] tx_data [0:15];
    logic model_pend = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cw_frontend i_i2cw_frontend (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(STRAP), .wp_i(wp), .cycle_busy_i(busy),
        .sda_oe_o(sda_oe), .wr_vld_o(wr_vld), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .commit_o(commit), .discard_o(discard)
    );

    // Record strobes and pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_vld && cap_n < 256) begin
                cap_addr[cap_n] = wr_addr;
                cap_data[cap_n] = wr_data;
                cap_n = cap_n + 1;
            end
            if (commit) commit_n = commit_n + 1;
            if (discard) discard_n = discard_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_addr(input logic [16:0] base, input int i);
        exp_addr = {base[16:7], 7'(base[6:0] + i)};
    endfunction

    function automatic logic exp_ctrl_ok(input logic [7:0] c, input logic bsy);
        exp_ctrl_ok = (c[7:4] == 4'b1010) && (c[2:1] == STRAP) && !c[0] &&
                      !(bsy && c[3] == model_pend);
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        wait_n(Q); sda_m = 1'b1; wait_n(Q); scl_m = 1'b1;
        wait_n(2*Q); sda_m = 1'b0; wait_n(2*Q); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        wait_n(Q); sda_m = 1'b0; wait_n(Q); scl_m = 1'b1;
        wait_n(2*Q); sda_m = 1'b1; wait_n(2*Q);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wait_n(Q); sda_m = b[i]; wait_n(Q); scl_m = 1'b1;
            wait_n(2*Q); scl_m = 1'b0;
        end
        wait_n(Q); sda_m = 1'b1; wait_n(Q); scl_m = 1'b1;
        wait_n(Q); ack = ~sda_line; wait_n(Q); scl_m = 1'b0;
    endtask

    // Full write command; all outcomes predicted from the requirements.
    task automatic run_txn(input string tag, input logic [7:0] ctrl, input logic [15:0] a,
                           input int n, input logic wpv, input logic bsy);
        logic ok, ak;
        int cb, c0, d0, bad, en;
        logic [16:0] base;
        ok = exp_ctrl_ok(ctrl, bsy);
        base = {ctrl[3], a};
        wp = wpv; busy = bsy;
        cb = cap_n; c0 = commit_n; d0 = discard_n; bad = 0;
        m_start();
        m_byte(ctrl, ak); if (ak !== ok) bad++;
        m_byte(a[15:8], ak); if (ak !== ok) bad++;
        m_byte(a[7:0], ak); if (ak !== ok) bad++;
        for (int i = 0; i < n; i++) begin
            m_byte(tx_data[i], ak); if (ak !== ok) bad++;
        end
        m_stop();
        wait_n(4);
        check({tag, " ack mismatches"}, bad, 0);
        en = ok ? n : 0;
        check({tag, " strobe count"}, cap_n - cb, en);
        for (int i = 0; i < en && cb + i < 256; i++) begin
            check({tag, " strobe addr"}, cap_addr[cb+i], exp_addr(base, i));
            check({tag, " strobe data"}, cap_data[cb+i], tx_data[i]);
        end
        check({tag, " commit"}, commit_n - c0, (ok && n > 0 && !wpv) ? 1 : 0);
        check({tag, " discard"}, discard_n - d0, (ok && n > 0 && wpv) ? 1 : 0);
        if (ok && n > 0 && !wpv) model_pend = ctrl[3];
        busy = 1'b0; wp = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ak;
        int cb, c0, d0;
        void'($urandom(32'h5EED_1234));
        wait_n(5);
        check("R2 reset sda_oe", sda_oe, 0);
        check("R5 reset strobe", wr_vld, 0);
        check("R7 reset commit", commit | discard, 0);
        rst_n = 1'b1;
        wait_n(5);

        tx_data[0] = 8'hA5;
        run_txn("R1 R4 R5 R7 byte write", {4'b1010, 1'b1, STRAP, 1'b0}, 16'h2345, 1, 0, 0);
        for (int i = 0; i < 4; i++) tx_data[i] = 8'h10 + 8'(i);
        run_txn("R6 page wrap", {4'b1010, 1'b1, STRAP, 1'b0}, 16'h23FE, 4, 0, 0);
        run_txn("R3 bad code", {4'b1011, 1'b0, STRAP, 1'b0}, 16'h0001, 2, 0, 0);
        run_txn("R2 bad straps", {4'b1010, 1'b0, 2'b01, 1'b0}, 16'h0001, 2, 0, 0);
        run_txn("R2 read direction", {4'b1010, 1'b0, STRAP, 1'b1}, 16'h0001, 2, 0, 0);
        run_txn("R8 protected", {4'b1010, 1'b0, STRAP, 1'b0}, 16'h0100, 3, 1, 0);
        run_txn("R8 next accepted", {4'b1010, 1'b0, STRAP, 1'b0}, 16'h0200, 2, 0, 0);
        run_txn("R11 address only", {4'b1010, 1'b1, STRAP, 1'b0}, 16'h0300, 0, 0, 0);
        check("R9 model block", model_pend, 0);
        run_txn("R9 busy same block", {4'b1010, 1'b0, STRAP, 1'b0}, 16'h0400, 2, 0, 1);
        run_txn("R9 busy other block", {4'b1010, 1'b1, STRAP, 1'b0}, 16'h0400, 2, 0, 1);

        // R10: repeated Start during address collection
        cb = cap_n; c0 = commit_n; d0 = discard_n;
        m_start(); m_byte({4'b1010, 1'b1, STRAP, 1'b0}, ak); m_byte(8'h55, ak);
        m_start(); m_byte({4'b1010, 1'b0, STRAP, 1'b0}, ak);
        check("R10 ctrl after restart ack", ak, 1);
        m_byte(8'h01, ak); m_byte(8'h02, ak); m_byte(8'h99, ak);
        m_stop(); wait_n(4);
        check("R10 strobe count", cap_n - cb, 1);
        check("R10 strobe addr", cap_addr[cb], 17'h00102);
        check("R10 strobe data", cap_data[cb], 8'h99);
        check("R10 commit", commit_n - c0, 1);
        check("R10 no discard", discard_n - d0, 0);
        model_pend = 1'b0;

        // R10: repeated Start after data drops the bytes
        cb = cap_n; c0 = commit_n; d0 = discard_n;
        m_start(); m_byte({4'b1010, 1'b0, STRAP, 1'b0}, ak);
        m_byte(8'h00, ak); m_byte(8'h10, ak); m_byte(8'h11, ak);
        m_start(); m_stop(); wait_n(4);
        check("R10 discard on restart", discard_n - d0, 1);
        check("R10 no commit on restart", commit_n - c0, 0);

        for (int t = 0; t < 30; t++) begin
            logic [7:0] ctrl;
            int n;
            if ($urandom_range(3) != 0)
                ctrl = {4'b1010, 1'($urandom_range(1)), STRAP, 1'b0};
            else
                ctrl = 8'($urandom);
            n = $urandom_range(5);
            for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom);
            run_txn("R1 R5 R6 random", ctrl, 16'($urandom), n,
                    $urandom_range(3) == 0, $urandom_range(3) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule